// File: doc/BRIEF.md
# Carry-Select Adder

This block adds two unsigned operands and a carry input, giving a sum of the same width and a carry output. It is fully combinational. The operands are cut into fixed-width sections. The lowest section is a plain ripple adder that takes the real carry input.

Every higher section holds two ripple adders that work in parallel. One adds with an incoming carry of 0 and the other with an incoming carry of 1. When the carry from the section below arrives, it steers a 2:1 multiplexer that picks the matching sum and carry-out.

The delay through the block is therefore one section adder plus one multiplexer for each section above the first. A chain of ripple sections in series would instead pay one full section delay for every section. The section width is a parameter. The last section may be narrower when the total width is not a multiple of the section width.

Top module: `carry_select_adder`

## Requirements
- R1: `{c_o, sum_o}` equals `a_i + b_i + c_i` taken as a WIDTH+1 bit unsigned sum, for every input combination.
- R2: The lowest SECT_W bits of `sum_o` equal the low SECT_W bits of `a_i[SECT_W-1:0] + b_i[SECT_W-1:0] + c_i`. They depend on no higher operand bit.
- R3: Each higher section forms two candidate results. The candidate built with carry 1 is exactly one more than the candidate built with carry 0, as a section-width-plus-one value. Whenever the carry-0 candidate carries out, the carry-1 candidate does too.
- R4: When the section below produces a carry, a higher section outputs its operand bits plus one. When no carry arrives, it outputs its operand bits plus zero.
- R5: `c_o` is the carry-out of the top section, chosen by the carry coming into that section.
- R6: With more than two sections, the carry selected in each section steers the next one. This also holds when the top section is narrower than SECT_W. An all-ones operand plus a carry-in of 1 therefore ripples a carry through every section.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| c_i | input | 1 | Carry into the lowest bit |
| sum_o | output | WIDTH | Sum bits |
| c_o | output | 1 | Carry out of the top bit |

## Verification
The hardest case to reach from the ports is a section whose carry select flips while its own operand bits stay the same. This is the only way to show that both speculative candidates are correct and that the right one is chosen. The stimulus holds the upper operand bits fixed and moves the low operand bits and `c_i` back and forth across the point where the low section carries. It also uses all-ones and alternating patterns, which make a carry cross every section of a 14-bit instance with an uneven top section.

// File: rtl/csa_pkg.sv
package csa_pkg;
  function automatic int sect_count(input int width, input int sect_w);
    return (width + sect_w - 1) / sect_w;
  endfunction

  function automatic int top_sect_w(input int width, input int sect_w);
    return width - (sect_count(width, sect_w) - 1) * sect_w;
  endfunction
endpackage

// File: rtl/csa_ripple.sv
module csa_ripple #(
  parameter int W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         c_i,
  output logic [W-1:0] sum_o,
  output logic         c_o
);
  logic [W:0] cy;
  assign cy[0] = c_i;

  for (genvar k = 0; k < W; k++) begin : g_bit
    assign sum_o[k] = a_i[k] ^ b_i[k] ^ cy[k];
    assign cy[k+1]  = (a_i[k] & b_i[k]) | (cy[k] & (a_i[k] ^ b_i[k]));
  end

  assign c_o = cy[W];

  always_comb begin
    if (!$isunknown({a_i, b_i, c_i}))
      assert_ripple_R2: assert ({c_o, sum_o} == ({1'b0, a_i} + {1'b0, b_i} + (W+1)'(c_i)))
        else $error("ripple sum mismatch");
  end
endmodule

// File: rtl/csa_section.sv
module csa_section #(
  parameter int W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sel_i,
  output logic [W-1:0] sum_o,
  output logic         c_o
);
  logic [W-1:0] sum0, sum1;
  logic         co0, co1;

  csa_ripple #(.W(W)) u_add0 (.a_i(a_i), .b_i(b_i), .c_i(1'b0), .sum_o(sum0), .c_o(co0));
  csa_ripple #(.W(W)) u_add1 (.a_i(a_i), .b_i(b_i), .c_i(1'b1), .sum_o(sum1), .c_o(co1));

  // late select on the incoming carry
  assign sum_o = sel_i ? sum1 : sum0;
  assign c_o   = sel_i ? co1  : co0;

  always_comb begin
    if (!$isunknown({a_i, b_i})) begin
      assert_spec_step_R3: assert ({co1, sum1} == {co0, sum0} + (W+1)'(1))
        else $error("speculative candidates not one apart");
      assert_carry_order_R3: assert (!co0 || co1)
        else $error("carry-1 candidate lost carry");
    end
  end
endmodule

// File: rtl/carry_select_adder.sv
module carry_select_adder
  import csa_pkg::*;
#(
  parameter int WIDTH  = 8,
  parameter int SECT_W = 4
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             c_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             c_o
);
  localparam int NS = sect_count(WIDTH, SECT_W);
  localparam int TW = top_sect_w(WIDTH, SECT_W);

  logic [NS:0] chain;
  assign chain[0] = c_i;

  for (genvar g = 0; g < NS; g++) begin : g_sect
    localparam int LO = g * SECT_W;
    localparam int SW = (g == NS - 1) ? TW : SECT_W;
    if (g == 0) begin : g_direct
      csa_ripple #(.W(SW)) u_add (
        .a_i(a_i[LO +: SW]), .b_i(b_i[LO +: SW]), .c_i(chain[g]),
        .sum_o(sum_o[LO +: SW]), .c_o(chain[g+1])
      );
    end else begin : g_spec
      csa_section #(.W(SW)) u_sec (
        .a_i(a_i[LO +: SW]), .b_i(b_i[LO +: SW]), .sel_i(chain[g]),
        .sum_o(sum_o[LO +: SW]), .c_o(chain[g+1])
      );
    end
  end

  assign c_o = chain[NS];

  always_comb begin
    if (!$isunknown({a_i, b_i, c_i}))
      assert_total_sum_R1: assert ({c_o, sum_o} == ({1'b0, a_i} + {1'b0, b_i} + (WIDTH+1)'(c_i)))
        else $error("total sum mismatch");
  end
endmodule

// File: tb/carry_select_adder_tb.sv
module carry_select_adder_tb;
  localparam int W  = 8;
  localparam int WW = 14;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [W-1:0]  a, b, s;
  logic          ci, co;
  logic [WW-1:0] wa, wb, ws;
  logic          wci, wco;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  carry_select_adder #(.WIDTH(W), .SECT_W(4)) u_dut (
    .a_i(a), .b_i(b), .c_i(ci), .sum_o(s), .c_o(co));
  carry_select_adder #(.WIDTH(WW), .SECT_W(4)) u_dut_wide (
    .a_i(wa), .b_i(wb), .c_i(wci), .sum_o(ws), .c_o(wco));

  function automatic logic [W:0] ref8(input logic [W-1:0] x, y, input logic c);
    return {1'b0, x} + {1'b0, y} + (W+1)'(c);
  endfunction

  function automatic logic [WW:0] ref14(input logic [WW-1:0] x, y, input logic c);
    return {1'b0, x} + {1'b0, y} + (WW+1)'(c);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic run8(input logic [W-1:0] x, y, input logic c);
    logic [W:0] e;
    logic [4:0] lo;
    logic [3:0] hi;
    @(posedge clk);
    a = x; b = y; ci = c;
    @(negedge clk);
    e  = ref8(x, y, c);
    lo = {1'b0, x[3:0]} + {1'b0, y[3:0]} + 5'(c);
    hi = x[7:4] + y[7:4] + 4'(lo[4]);
    chk({co, s} == e, "R1", 32'({co, s}), 32'(e));
    chk(s[3:0] == lo[3:0], "R2", 32'(s[3:0]), 32'(lo[3:0]));
    chk(s[7:4] == hi, lo[4] ? "R4 carry" : "R4 nocarry", 32'(s[7:4]), 32'(hi));
    chk(co == e[W], "R5", 32'(co), 32'(e[W]));
  endtask

  task automatic run14(input logic [WW-1:0] x, y, input logic c);
    logic [WW:0] e;
    @(posedge clk);
    wa = x; wb = y; wci = c;
    @(negedge clk);
    e = ref14(x, y, c);
    chk({wco, ws} == e, "R6", 32'({wco, ws}), 32'(e));
  endtask

  initial begin
    a = '0; b = '0; ci = 1'b0; wa = '0; wb = '0; wci = 1'b0;
    void'($urandom(32'h1d5a));
    @(negedge clk);
    chk(s == '0 && co == 1'b0, "R1 zero", 32'({co, s}), 32'h0);
    // low carry toggles while the upper nibble is held (R3, R4)
    for (int hv = 0; hv < 16; hv++) begin
      run8({4'(hv), 4'hf}, {4'h5, 4'h0}, 1'b0);
      run8({4'(hv), 4'hf}, {4'h5, 4'h0}, 1'b1);
      run8({4'(hv), 4'h8}, {4'hf, 4'h8}, 1'b0);
      run8({4'(hv), 4'h7}, {4'hf, 4'h8}, 1'b0);
    end
    run8(8'hff, 8'h00, 1'b1);
    run8(8'hff, 8'hff, 1'b1);
    run8(8'h80, 8'h80, 1'b0);
    run8(8'haa, 8'h55, 1'b1);
    // multi-section chain, narrow top section (R6)
    run14('1, '0, 1'b1);
    run14('1, '1, 1'b1);
    run14(14'h2aaa, 14'h1555, 1'b1);
    run14(14'h0fff, 14'h0001, 1'b0);
    run14(14'h3000, 14'h1000, 1'b0);
    for (int n = 0; n < 3000; n++) begin
      run8(W'($urandom), W'($urandom), 1'($urandom));
      run14(WW'($urandom), WW'($urandom), 1'($urandom));
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog act=0 exp=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule